// File: doc/BRIEF.md
# Interrupt Deactivation Write Handler

This block takes software writes that end an interrupt's active state when priority drop and deactivation are handled as two separate steps. A write carries a 32-bit word. Its low bits name an interrupt. A configuration input chooses whether 16 or 24 identifier bits are implemented. A mode input says whether deactivation is split from priority drop. When it is split, the write clears the named interrupt's active bit. This happens even if no priority drop came first, and the running-priority record is left as it was.

The block holds one active bit for each of a parameterized number of identifiers. An upstream acknowledge path sets these bits through a simple set port. The block also holds a running-priority value that only the priority-drop side loads. Every successful deactivation produces a one-cycle pulse that carries the masked identifier. A write made while the mode is not split is dropped. When the build enables it, such a write raises a one-cycle system-error pulse. The last written word can be read back with its reserved bits forced to zero.

Top module: `dir_deact_unit`

## Requirements
- R1: After reset, every active bit is 0, `deact_pulse` and `serr_pulse` are 0, `rdback` is 0 and `run_prio` is 0.
- R2: Write data bits [31:24] are reserved: they never select an interrupt, and `rdback[31:24]` always reads 0; `rdback` shows the masked identifier of the latest write one cycle after the strobe.
- R3: With `wide_id` = 0 only bits [15:0] form the identifier; bits [23:16] are taken as zero (e.g. data 0xABFF0005 names interrupt 5).
- R4: With `wide_id` = 1 bits [23:0] form the identifier (e.g. data 0x00010003 names 65539, not 3).
- R5: A write while `eoi_split` = 0 changes no active bit and produces no `deact_pulse`.
- R6: With `SERR_EN` = 1, a write while `eoi_split` = 0 raises `serr_pulse` for exactly one cycle, in the cycle after the strobe.
- R7: A write while `eoi_split` = 1 that names an in-range interrupt whose active bit is 1 clears that bit at the next clock edge; in the same cycle `deact_pulse` is 1 for one cycle and `deact_id` carries the masked identifier.
- R8: `run_prio` changes only on `prio_load`; deactivate writes never alter it.
- R9: A split-mode write that names an identifier at or above `NUM_IRQ`, or one whose active bit is already 0, changes nothing and raises neither pulse.
- R10: `act_set` = 1 sets the active bit of `act_set_id` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Deactivate write strobe |
| wr_data | input | 32 | Write word; identifier in the low bits |
| eoi_split | input | 1 | 1 = deactivation split from priority drop |
| wide_id | input | 1 | 1 = 24-bit identifiers, 0 = 16-bit |
| act_set | input | 1 | Mark an interrupt active |
| act_set_id | input | IDX_W | Interrupt to mark active |
| prio_load | input | 1 | Load running priority |
| prio_val | input | PRIO_W | Running priority value |
| active_vec | output | NUM_IRQ | Active bit per interrupt |
| run_prio | output | PRIO_W | Running-priority record |
| deact_pulse | output | 1 | One-cycle deactivation event |
| deact_id | output | 24 | Masked identifier of the deactivation |
| serr_pulse | output | 1 | One-cycle system-error event |
| rdback | output | 32 | Last write, reserved bits zeroed |

## Verification
The assertions assume that a set and a deactivation never target the same interrupt in the same cycle. They also assume that inputs hold known values from the first clock onward. The stimulus starts every input at 0 during reset and drives the set port only in cycles with no write. The deactivation checks assume that the active vector is changed only through these two paths. Because of this, the bench keeps its own model of the active bits and updates it alongside each write and set.

// File: rtl/dir_pkg.sv
package dir_pkg;

  localparam int unsigned ID_W = 24;

  // Identifier from a write word: 16 or 24 implemented bits
  function automatic logic [ID_W-1:0] mask_id(input logic [31:0] d, input logic wide);
    return wide ? d[23:0] : {8'h00, d[15:0]};
  endfunction

  function automatic logic id_in_range(input logic [ID_W-1:0] id, input int unsigned n);
    return ({8'h00, id} < n);
  endfunction

  function automatic logic [31:0] readback_word(input logic [ID_W-1:0] id);
    return {8'h00, id};
  endfunction

endpackage

// File: rtl/dir_decode.sv
module dir_decode #(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic               eoi_split,
  input  logic               wide_id,
  input  logic [NUM_IRQ-1:0] active_vec,
  output logic [23:0]        id_masked,
  output logic               hit,
  output logic               ignored_wr,
  output logic [NUM_IRQ-1:0] clr_vec
);
  import dir_pkg::*;

  logic             in_rng;
  logic [IDX_W-1:0] idx;
  logic             bit_set;

  always_comb begin
    id_masked  = mask_id(wr_data, wide_id);
    in_rng     = id_in_range(id_masked, NUM_IRQ);
    idx        = id_masked[IDX_W-1:0];
    bit_set    = in_rng ? active_vec[idx] : 1'b0;
    hit        = wr_en && eoi_split && in_rng && bit_set;
    ignored_wr = wr_en && !eoi_split;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_clr
    assign clr_vec[i] = hit && (idx == IDX_W'(i));
  end

endmodule

// File: rtl/dir_active_array.sv
module dir_active_array #(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic [NUM_IRQ-1:0] clr_vec,
  output logic [NUM_IRQ-1:0] active_vec
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    logic set_here;
    assign set_here = set_en && (set_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)          active_vec[i] <= 1'b0;
      else if (set_here)   active_vec[i] <= 1'b1;
      else if (clr_vec[i]) active_vec[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/dir_prio_hold.sv
module dir_prio_hold #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PRIO_W-1:0] val,
  output logic [PRIO_W-1:0] prio
);

  always_ff @(posedge clk) begin
    if (!rst_n)    prio <= '0;
    else if (load) prio <= val;
  end

endmodule

// File: rtl/dir_deact_unit.sv
module dir_deact_unit #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 8,
  parameter bit          SERR_EN = 1'b1,
  localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic               eoi_split,
  input  logic               wide_id,
  input  logic               act_set,
  input  logic [IDX_W-1:0]   act_set_id,
  input  logic               prio_load,
  input  logic [PRIO_W-1:0]  prio_val,
  output logic [NUM_IRQ-1:0] active_vec,
  output logic [PRIO_W-1:0]  run_prio,
  output logic               deact_pulse,
  output logic [23:0]        deact_id,
  output logic               serr_pulse,
  output logic [31:0]        rdback
);
  import dir_pkg::*;

  // Named internal events, visible to the bound checker
  logic [23:0]        id_masked;
  logic               hit;
  logic               ignored_wr;
  logic [NUM_IRQ-1:0] clr_vec;

  dir_decode #(.NUM_IRQ(NUM_IRQ)) u_decode (
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .eoi_split  (eoi_split),
    .wide_id    (wide_id),
    .active_vec (active_vec),
    .id_masked  (id_masked),
    .hit        (hit),
    .ignored_wr (ignored_wr),
    .clr_vec    (clr_vec)
  );

  dir_active_array #(.NUM_IRQ(NUM_IRQ)) u_active (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (act_set),
    .set_idx    (act_set_id),
    .clr_vec    (clr_vec),
    .active_vec (active_vec)
  );

  dir_prio_hold #(.PRIO_W(PRIO_W)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (prio_load),
    .val   (prio_val),
    .prio  (run_prio)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deact_pulse <= 1'b0;
      deact_id    <= '0;
      rdback      <= '0;
    end else begin
      deact_pulse <= hit;
      if (hit)   deact_id <= id_masked;
      if (wr_en) rdback   <= readback_word(id_masked);
    end
  end

  if (SERR_EN) begin : g_serr
    always_ff @(posedge clk) begin
      if (!rst_n) serr_pulse <= 1'b0;
      else        serr_pulse <= ignored_wr;
    end
  end else begin : g_no_serr
    assign serr_pulse = 1'b0;
  end

endmodule

// File: rtl/dir_deact_checker.sv
module dir_deact_checker #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 8,
  parameter bit          SERR_EN = 1'b1,
  localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               eoi_split,
  input logic               wide_id,
  input logic               act_set,
  input logic               prio_load,
  input logic [NUM_IRQ-1:0] active_vec,
  input logic [PRIO_W-1:0]  run_prio,
  input logic               deact_pulse,
  input logic [23:0]        deact_id,
  input logic               serr_pulse,
  input logic [31:0]        rdback,
  input logic [23:0]        id_masked,
  input logic               hit,
  input logic               ignored_wr
);

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdback[31:24] == 8'h00);

  assert_narrow_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wide_id) |=> rdback[23:16] == 8'h00);

  assert_mode0_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ignored_wr && !act_set) |=> (active_vec == $past(active_vec)) && !deact_pulse);

  assert_serr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> $past(ignored_wr));

  if (SERR_EN) begin : g_serr_chk
    assert_serr_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ignored_wr |=> serr_pulse);
  end

  assert_deact_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> deact_pulse && (deact_id == $past(id_masked)));

  assert_deact_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    deact_pulse |-> !active_vec[deact_id[IDX_W-1:0]] && $past(wr_en && eoi_split));

  assert_prio_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_load |=> $stable(run_prio));

  assert_no_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && eoi_split && !hit) |=> !deact_pulse && !serr_pulse);

  assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({deact_pulse, serr_pulse}));

endmodule

bind dir_deact_unit dir_deact_checker #(
  .NUM_IRQ (NUM_IRQ),
  .PRIO_W  (PRIO_W),
  .SERR_EN (SERR_EN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .eoi_split   (eoi_split),
  .wide_id     (wide_id),
  .act_set     (act_set),
  .prio_load   (prio_load),
  .active_vec  (active_vec),
  .run_prio    (run_prio),
  .deact_pulse (deact_pulse),
  .deact_id    (deact_id),
  .serr_pulse  (serr_pulse),
  .rdback      (rdback),
  .id_masked   (id_masked),
  .hit         (hit),
  .ignored_wr  (ignored_wr)
);

// File: tb/dir_deact_unit_bench.sv
module dir_deact_unit_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N   = 32;
  localparam int unsigned PW  = 8;
  localparam int unsigned IW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          eoi_split = 1'b0;
  logic          wide_id = 1'b0;
  logic          act_set = 1'b0;
  logic [IW-1:0] act_set_id = '0;
  logic          prio_load = 1'b0;
  logic [PW-1:0] prio_val = '0;
  logic [N-1:0]  active_vec;
  logic [PW-1:0] run_prio;
  logic          deact_pulse;
  logic [23:0]   deact_id;
  logic          serr_pulse;
  logic [31:0]   rdback;

  int tests = 0;
  int fails = 0;
  logic [N-1:0] exp_act = '0;
  logic [24:0]  expq[$];   // bit 24: 1 = error event, 0 = deactivation; low bits: id

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_deact_unit #(.NUM_IRQ(N), .PRIO_W(PW), .SERR_EN(1'b1)) u_dir_deact_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .eoi_split(eoi_split), .wide_id(wide_id), .act_set(act_set),
    .act_set_id(act_set_id), .prio_load(prio_load), .prio_val(prio_val),
    .active_vec(active_vec), .run_prio(run_prio), .deact_pulse(deact_pulse),
    .deact_id(deact_id), .serr_pulse(serr_pulse), .rdback(rdback)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Monitor: pop and compare each produced event
  always @(negedge clk) begin
    if (rst_n && (deact_pulse || serr_pulse)) begin
      if (expq.size() == 0) begin
        tests++; fails++;
        $display("FAIL R9: actual unexpected event deact=%0b serr=%0b id=%0d expected none",
                 deact_pulse, serr_pulse, deact_id);
      end else begin
        logic [24:0] e;
        e = expq.pop_front();
        if (e[24]) check("R6 error event", {31'b0, serr_pulse && !deact_pulse}, 32'd1);
        else       check("R7 deactivation id", {7'b0, deact_pulse, deact_id}, {7'b0, 1'b1, e[23:0]});
      end
    end
  end

  function automatic logic [23:0] model_id(input logic [31:0] d, input logic w);
    logic [23:0] r;
    r = d[23:0];
    if (!w) r[23:16] = 8'h00;
    return r;
  endfunction

  // Driver: predicts, pushes expectation, drives one strobe cycle
  task automatic predict(input logic [31:0] d, input logic eoi, input logic w);
    logic [23:0] id;
    id = model_id(d, w);
    if (!eoi) expq.push_back({1'b1, 24'h0});
    else if (id < 24'(N) && exp_act[id[IW-1:0]]) begin
      expq.push_back({1'b0, id});
      exp_act[id[IW-1:0]] = 1'b0;
    end
  endtask

  task automatic dwrite(input logic [31:0] d, input logic eoi, input logic w, input string req);
    @(negedge clk);
    predict(d, eoi, w);
    wr_en = 1'b1; wr_data = d; eoi_split = eoi; wide_id = w;
    @(negedge clk);
    wr_en = 1'b0;
    check(req, active_vec, exp_act);
    check("R2 readback", rdback, {8'h00, model_id(d, w)});
  endtask

  task automatic set_act(input int id);
    @(negedge clk);
    act_set = 1'b1; act_set_id = IW'(id);
    exp_act[id] = 1'b1;
    @(negedge clk);
    act_set = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 active", active_vec, 32'h0);
    check("R1 pulses", {30'b0, deact_pulse, serr_pulse}, 32'h0);
    check("R1 readback", rdback, 32'h0);
    check("R1 prio", {24'b0, run_prio}, 32'h0);
    rst_n = 1'b1;

    @(negedge clk); prio_load = 1'b1; prio_val = 8'h40;
    @(negedge clk); prio_load = 1'b0;
    check("R8 prio load", {24'b0, run_prio}, 32'h40);

    set_act(3); set_act(5); set_act(7); set_act(31);
    check("R10 set", active_vec, 32'h8000_00A8);

    dwrite(32'h0000_0003, 1'b0, 1'b1, "R5 mode0 ignored");
    dwrite(32'hABFF_0005, 1'b1, 1'b0, "R3 narrow id 5");
    dwrite(32'h0001_0003, 1'b1, 1'b1, "R4 wide id out of range");
    dwrite(32'h0000_0005, 1'b1, 1'b1, "R9 already clear");
    dwrite(32'hFF00_001F, 1'b1, 1'b1, "R7 id 31 reserved set");
    dwrite(32'h0000_0028, 1'b1, 1'b0, "R9 id 40 out of range");
    check("R8 prio kept", {24'b0, run_prio}, 32'h40);

    // back-to-back deactivations
    @(negedge clk);
    predict(32'h3, 1'b1, 1'b0);
    wr_en = 1'b1; wr_data = 32'h3; eoi_split = 1'b1; wide_id = 1'b0;
    @(negedge clk);
    predict(32'h7, 1'b1, 1'b0);
    wr_data = 32'h7;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 back-to-back", active_vec, exp_act);
    check("R7 all clear", active_vec, 32'h0);

    // mode 0 after everything clear still signals error
    set_act(9);
    dwrite(32'h0000_0009, 1'b0, 1'b0, "R6 mode0 error");
    check("R5 bit kept", active_vec, 32'h0000_0200);
    check("R8 prio final", {24'b0, run_prio}, 32'h40);

    repeat (3) @(negedge clk);
    check("R7 queue drained", expq.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule